// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block runs the digital side of a successive-approximation analogue-to-digital conversion. It drives a trial code into an external DAC, reads back one comparator bit that reports whether the DAC level is at or below the sampled input, and keeps or drops each bit of the code in turn. The first bit resolved is the most significant one. The analogue parts (the DAC, the comparator and any sample-and-hold) are outside the block.

A one-cycle start pulse clears every result bit and resets a decoded one-hot bit sequencer to the MSB. The sequencer has one position per result bit plus a final stop position. The stop position inhibits further counting and also serves as the end-of-conversion flag. Each result bit has its own set/clear storage cell. Every bit period lasts two clock cycles. In the first cycle the selected bit is switched on. In the second cycle the DAC has settled, and the comparator decides whether the bit stays on. No other bit changes during the period.

With the default width of 8 bits, one conversion takes 16 clock cycles after the start edge. At any clock above about 1.7 MHz this gives more than 100,000 conversions per second.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, trial_code_o and result_o are 0 and eoc_o is 0.
- R2: A start_i pulse sampled high at a clock edge clears every result bit, so trial_code_o is 0 after that edge. It also restarts the sequencer at the MSB, so bit CODE_BITS-1 is driven to 1 on the following edge.
- R3: The sequencer selects at most one result bit at a time, stepping from the MSB to the LSB. While bit i is under trial, trial_code_o holds the already-decided upper bits, a 1 at position i, and 0 in every bit below i.
- R4: A bit under trial is kept when cmp_i is 1 (DAC level at or below the input) during the second cycle of its period. It is cleared when cmp_i is 0.
- R5: eoc_o rises exactly 2*CODE_BITS clock edges after the start edge. The sequencer then stops, and result_o equals the largest code whose DAC level is at or below the input. For an input above full scale, result_o is all ones.
- R6: While eoc_o is 1 and no start pulse arrives, result_o and eoc_o hold their values whatever cmp_i does.
- R7: A start pulse during a conversion aborts it. The conversion restarts from the MSB with all bits cleared, and the result depends only on the input seen after the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start-of-conversion pulse |
| cmp_i | input | 1 | Comparator: 1 when DAC level is at or below the input |
| trial_code_o | output | CODE_BITS | Code driving the external DAC |
| eoc_o | output | 1 | End of conversion; result_o is valid while high |
| result_o | output | CODE_BITS | Converted code |

## Verification
A wrong sequencer position or phase shows up on trial_code_o within one bit period (two cycles): either the trial bit appears in the wrong place, or a lower bit is set early. A bad storage cell shows up in the final code at the edge where eoc_o rises. An inhibit fault shows up as result_o or eoc_o changing during the hold window. The bench checks trial_code_o in the set phase of every bit against an ideal model of the input. It also checks the exact cycle where eoc_o rises, so an off-by-one in the schedule is caught at the first conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // Two clock cycles make up one bit period: the trial bit is switched on,
    // then the comparator decides whether it stays.
    typedef enum logic {
        PH_SET  = 1'b0,
        PH_EVAL = 1'b1
    } phase_e;

endpackage

// File: rtl/sar_bit_sequencer.sv
module sar_bit_sequencer
    import sar_pkg::*;
#(
    parameter int unsigned CODE_BITS = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    output logic [CODE_BITS-1:0] sel_o,
    output logic                 set_phase_o,
    output logic                 eval_phase_o,
    output logic                 done_o
);

    localparam logic [CODE_BITS-1:0] MSB_ONEHOT = {1'b1, {(CODE_BITS-1){1'b0}}};

    typedef struct packed {
        logic [CODE_BITS-1:0] sel;
        logic                 done;
        phase_e               phase;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.sel   = MSB_ONEHOT;
            s_d.done  = 1'b0;
            s_d.phase = PH_SET;
        end else if (s_q.sel != '0) begin
            if (s_q.phase == PH_SET) begin
                s_d.phase = PH_EVAL;
            end else begin
                s_d.phase = PH_SET;
                s_d.sel   = s_q.sel >> 1;
                s_d.done  = s_q.sel[0];
            end
        end
        // At the stop position (or when idle) the count is inhibited.
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{sel: '0, done: 1'b0, phase: PH_SET};
        end else begin
            s_q <= s_d;
        end
    end

    assign sel_o        = s_q.sel;
    assign done_o       = s_q.done;
    assign set_phase_o  = (s_q.phase == PH_SET);
    assign eval_phase_o = (s_q.phase == PH_EVAL);

    // R3: at most one position (bit selects plus stop position) active
    a_r3_onehot_position: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({s_q.sel, s_q.done}));

    // R2: a start pulse always lands on the MSB in the set phase
    a_r2_start_to_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (sel_o == MSB_ONEHOT) && !done_o && set_phase_o);

    // R5: the stop position inhibits counting until the next start
    a_r5_count_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> (done_o && (sel_o == '0)));

endmodule

// File: rtl/sar_bit_cell.sv
module sar_bit_cell (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic sel_i,
    input  logic set_phase_i,
    input  logic eval_phase_i,
    input  logic cmp_i,
    output logic bit_o
);

    logic bit_d, bit_q;

    always_comb begin
        bit_d = bit_q;
        if (clear_i) begin
            bit_d = 1'b0;
        end else if (sel_i && set_phase_i) begin
            bit_d = 1'b1;
        end else if (sel_i && eval_phase_i && !cmp_i) begin
            bit_d = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= bit_d;
        end
    end

    assign bit_o = bit_q;

    // R4: a trial bit with the DAC at or below the input survives evaluation
    a_r4_keep_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && eval_phase_i && cmp_i && !clear_i) |=> bit_o);

    // R4: a trial bit with the DAC above the input is dropped
    a_r4_drop_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && eval_phase_i && !cmp_i && !clear_i) |=> !bit_o);

    // R2: start clears the cell
    a_r2_clear_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> !bit_o);

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int unsigned CODE_BITS = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic                 cmp_i,
    output logic [CODE_BITS-1:0] trial_code_o,
    output logic                 eoc_o,
    output logic [CODE_BITS-1:0] result_o
);

    logic [CODE_BITS-1:0] sel;
    logic [CODE_BITS-1:0] code;
    logic                 set_phase;
    logic                 eval_phase;
    logic                 done;

    sar_bit_sequencer #(
        .CODE_BITS (CODE_BITS)
    ) i_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .sel_o        (sel),
        .set_phase_o  (set_phase),
        .eval_phase_o (eval_phase),
        .done_o       (done)
    );

    for (genvar gi = 0; gi < CODE_BITS; gi++) begin : g_cell
        sar_bit_cell i_cell (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .clear_i      (start_i),
            .sel_i        (sel[gi]),
            .set_phase_i  (set_phase),
            .eval_phase_i (eval_phase),
            .cmp_i        (cmp_i),
            .bit_o        (code[gi])
        );
    end

    assign trial_code_o = code;
    assign result_o     = code;
    assign eoc_o        = done;

    // R3: bits below the one under trial are still zero
    a_r3_lower_bits_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel != '0) |-> ((code & (sel - 1'b1)) == '0));

    // R6: result and flag hold while the conversion is finished
    a_r6_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoc_o && !start_i) |=> ($stable(result_o) && eoc_o));

    // R7: a start pulse mid-conversion empties the code
    a_r7_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !eoc_o) |=> (result_o == '0) && !eoc_o);

endmodule

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;

    localparam int W      = 8;
    localparam int MAXC   = (1 << W) - 1;
    localparam int FRAC   = 16;          // input resolution: 1/16 LSB

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp;
    logic [W-1:0] trial;
    logic         eoc;
    logic [W-1:0] result;
    int           vin = 0;               // analogue input in 1/16 LSB units

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    // Behavioural DAC plus comparator: 1 when DAC level <= input
    assign cmp = ((int'(trial) * FRAC) <= vin);

    sar_conv_ctrl #(.CODE_BITS(W)) i_sar_conv_ctrl (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start),
        .cmp_i        (cmp),
        .trial_code_o (trial),
        .eoc_o        (eoc),
        .result_o     (result)
    );

    function automatic int ideal_code(int v);
        int c;
        c = v / FRAC;
        if (c > MAXC) c = MAXC;
        return c;
    endfunction

    function automatic int expected_trial(int v, int i);
        int upper_mask;
        upper_mask = MAXC & ~((1 << (i + 1)) - 1);
        return (ideal_code(v) & upper_mask) | (1 << i);
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(int v);
        @(negedge clk);
        vin   = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Full conversion from a start pulse; checks every bit period.
    task automatic convert(int v);
        pulse_start(v);
        check("R2", int'(trial), 0, "code after start");
        check("R2", int'(eoc), 0, "eoc after start");
        for (int i = W - 1; i >= 0; i--) begin
            @(negedge clk);
            check("R3", int'(trial), expected_trial(v, i), "trial code in set phase");
            @(negedge clk);
            if (i > 0) check("R5", int'(eoc), 0, "eoc early");
        end
        check("R5", int'(eoc), 1, "eoc after 2*W edges");
        check("R4", int'(result), ideal_code(v), "final code");
    endtask

    task automatic hold_test(int cyc);
        int held;
        held = int'(result);
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            vin = int'($urandom_range(0, (MAXC + 1) * FRAC + 100));
            @(negedge clk);
            check("R6", int'(result), held, "result hold");
            check("R6", int'(eoc), 1, "eoc hold");
        end
    endtask

    task automatic abort_test(int va, int vb, int cyc);
        pulse_start(va);
        repeat (cyc) @(negedge clk);
        pulse_start(vb);
        check("R7", int'(trial), 0, "code cleared on abort");
        repeat (2 * W) @(negedge clk);
        check("R7", int'(eoc), 1, "eoc after restart");
        check("R7", int'(result), ideal_code(vb), "result after restart");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !ended) begin
            ended = 1;
            fails++;
            $display("FAIL R5 watchdog expired: actual %0d expected <150000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1", int'(trial), 0, "reset code");
        check("R1", int'(eoc), 0, "reset eoc");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(result), 0, "idle code");
        check("R1", int'(eoc), 0, "idle eoc");

        // Directed corners
        convert(0);
        convert(MAXC * FRAC + FRAC - 1);
        convert((MAXC + 1) * FRAC + 50);     // above full scale -> all ones
        convert(128 * FRAC);                 // exactly on MSB threshold
        convert(128 * FRAC - 1);
        convert(85 * FRAC + 7);              // alternating bits
        convert(170 * FRAC);
        convert(1 * FRAC);
        hold_test(6);

        abort_test(200 * FRAC, 37 * FRAC + 3, 5);
        abort_test(3 * FRAC, 250 * FRAC, 14);
        abort_test(90 * FRAC, 0, 1);
        hold_test(3);

        // Random conversions
        for (int n = 0; n < 60; n++) begin
            convert(int'($urandom_range(0, (MAXC + 1) * FRAC + 64)));
            if (n % 10 == 0) hold_test(2);
            if (n % 15 == 7)
                abort_test(int'($urandom_range(0, MAXC * FRAC)),
                           int'($urandom_range(0, MAXC * FRAC)),
                           int'($urandom_range(1, 2 * W - 1)));
        end

        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule